// File: doc/BRIEF.md
# Serial Configuration Loader

This block loads a bitstream into a programmable device through its serial configuration pins. It drives three outputs: an active-low program line, a configuration clock and a data line. It watches two inputs from the device: an init line and a done line. A single start pulse runs the whole load. The block pulses program low, waits for init to fall, and releases program. It then waits for init to rise, shifts the payload out one bit at a time, and finally waits for done. Each of the three waits can time out, and each timeout has its own error code.

Payload arrives in one of two ways, chosen by `packed_mode` when start is taken. In plain mode, bytes arrive on a valid/ready byte stream and are shifted out most-significant bit first. In packed mode, an external decompressor supplies single bits on a valid/ready bit stream. In that mode the block first sends a fixed 16-bit lead-in pattern and then passes the decompressor's bits on in order.

Both streams follow the usual valid/ready rules. A word moves on a rising clock edge where valid and ready are both high. The source must hold data and last stable while valid is high and ready is low. The block never raises ready on the stream that the current mode does not use, and raises neither outside the shifting phase. `byte_ready` stays low while the previous byte is still being shifted. `zb_ready` is high only while the serializer is free to take a bit.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, and while idle, prog_n, cclk and cdata are all high, busy and ok are low and err_code is 0.
- R2: A start pulse accepted while idle or halted drives prog_n low. prog_n returns high once init_in (passed through a two-flop synchronizer) is seen low at a poll. prog_n stays high for the rest of the load.
- R3: Each wait polls its condition on its first cycle and then every POLL_CYC cycles. After POLL_LIMIT failed polls it gives up. For a failed init-fall wait, err_code becomes nonzero exactly (POLL_LIMIT-1)*POLL_CYC+1 cycles after the clock edge that drove prog_n low.
- R4: Each bit takes four steps of STEP_CYC cycles each: cclk low, cdata set to the bit, cclk high, cdata back to 1. cdata holds the bit across the rising cclk edge and is 1 whenever cclk falls.
- R5: In plain mode (packed_mode=0) each byte is sent most-significant bit first, and bytes go out in the order they were accepted.
- R6: In packed mode (packed_mode=1) the bits of 16'hFF20 are sent first, most-significant bit first. The stream bits follow in arrival order.
- R7: The word or bit marked last ends the shifting phase, and the done wait then starts.
- R8: err_code encoding: 0 none, 1 init never fell, 2 init never rose after program release, 3 done never rose. ok goes high only on a successful done wait, and ok is never high together with busy or a nonzero code.
- R9: After an error, the block halts with err_code held and all three pins high until the next start. That start clears err_code and ok and begins a new load.
- R10: During the two init waits, cclk does not pulse and neither stream's ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load; taken when idle or halted |
| packed_mode | input | 1 | 0: byte payload, 1: lead-in plus bit stream |
| init_in | input | 1 | Device init line (asynchronous) |
| done_in | input | 1 | Device done line (asynchronous) |
| prog_n | output | 1 | Active-low program line |
| cclk | output | 1 | Configuration clock |
| cdata | output | 1 | Configuration data |
| byte_valid | input | 1 | Byte stream valid |
| byte_data | input | 8 | Byte stream data |
| byte_last | input | 1 | Marks the final byte |
| byte_ready | output | 1 | Byte stream ready |
| zb_valid | input | 1 | Bit stream valid |
| zb_bit | input | 1 | Bit stream data |
| zb_last | input | 1 | Marks the final bit |
| zb_ready | output | 1 | Bit stream ready |
| busy | output | 1 | A load is in progress |
| ok | output | 1 | Last load finished successfully |
| err_code | output | 2 | Error code of the last load |

## Verification
The start edge lowers prog_n at once. After a stuck-high init, the error code appears exactly (POLL_LIMIT-1)*POLL_CYC+1 edges later. The bench counts falling-clock samples from the first sample that shows prog_n low and compares the count with that figure. Shifted bits are taken on every rising cclk, the same instant the receiving device would sample them. Results that come after a poll are read only once busy has dropped, and the R9 restart is checked on the first falling edge after the start edge.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FALL, ST_RISE, ST_SHIFT, ST_DONE, ST_OK, ST_ERR
  } seq_state_t;

  typedef enum logic [1:0] {FD_OFF, FD_LEAD, FD_BYTE, FD_BITS} feed_state_t;

  localparam logic [1:0] ERR_NONE      = 2'd0;
  localparam logic [1:0] ERR_INIT_FALL = 2'd1;
  localparam logic [1:0] ERR_INIT_RISE = 2'd2;
  localparam logic [1:0] ERR_DONE      = 2'd3;

  localparam int LEAD_W = 16;
  localparam logic [LEAD_W-1:0] LEAD_PAT = 16'hFF20;
endpackage

// File: rtl/cfgl_poller.sv
module cfgl_poller #(
  parameter int POLL_CYC   = 100000,
  parameter int POLL_LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic cond,
  output logic met,
  output logic expired
);
  localparam int CW = $clog2(POLL_CYC + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  logic          active;
  logic [CW-1:0] cyc;
  logic [PW-1:0] polls;
  logic          poll_now, last_poll;

  assign poll_now  = active && (cyc == '0);
  assign last_poll = (polls == PW'(POLL_LIMIT - 1));
  assign met       = poll_now && cond;
  assign expired   = poll_now && !cond && last_poll;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cyc    <= '0;
      polls  <= '0;
    end else if (arm) begin
      active <= 1'b1;
      cyc    <= '0;
      polls  <= '0;
    end else if (poll_now) begin
      if (cond || last_poll) begin
        active <= 1'b0;
      end else begin
        polls <= polls + 1'b1;
        cyc   <= CW'(POLL_CYC - 1);
      end
    end else if (active) begin
      cyc <= cyc - 1'b1;
    end
  end

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (int'(polls) < POLL_LIMIT)); // R3
  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !active || arm); // R3
endmodule

// File: rtl/cfgl_bitser.sv
module cfgl_bitser #(
  parameter int STEP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  input  logic in_last,
  output logic in_ready,
  output logic cclk,
  output logic cdata,
  output logic fin
);
  localparam int SW = $clog2(STEP_CYC + 1);

  logic          busy, bit_q, last_q;
  logic [1:0]    phase;
  logic [SW-1:0] cnt;

  assign in_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= 2'd0;
      cnt    <= '0;
      cclk   <= 1'b1;
      cdata  <= 1'b1;
      fin    <= 1'b0;
      bit_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          busy   <= 1'b1;
          phase  <= 2'd0;
          cnt    <= SW'(STEP_CYC - 1);
          cclk   <= 1'b0;
          bit_q  <= in_bit;
          last_q <= in_last;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt   <= SW'(STEP_CYC - 1);
        phase <= phase + 2'd1;
        case (phase)
          2'd0: cdata <= bit_q;
          2'd1: cclk  <= 1'b1;
          2'd2: cdata <= 1'b1;
          default: begin
            busy <= 1'b0;
            fin  <= last_q;
          end
        endcase
      end
    end
  end

  AST_DATA_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk) |-> $stable(cdata)); // R4
  AST_DATA_HIGH_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cclk) |-> cdata); // R4
endmodule

// File: rtl/cfgl_feed.sv
module cfgl_feed
  import cfgl_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              clear,
  input  logic              packed_mode,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_last,
  output logic              byte_ready,
  input  logic              zb_valid,
  input  logic              zb_bit,
  input  logic              zb_last,
  output logic              zb_ready,
  output logic              out_valid,
  output logic              out_bit,
  output logic              out_last,
  input  logic              out_ready
);
  localparam int LW = $clog2(LEAD_W);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [LW-1:0] LTOP = LW'(LEAD_W - 1);
  localparam logic [BW-1:0] BTOP = BW'(BYTE_W - 1);

  feed_state_t       st;
  logic [BYTE_W-1:0] sreg;
  logic [LW-1:0]     lidx;
  logic [BW-1:0]     bidx;
  logic              have, blast;

  assign byte_ready = (st == FD_BYTE) && !have;
  assign zb_ready   = (st == FD_BITS) && out_ready;

  always_comb begin
    out_valid = 1'b0;
    out_bit   = 1'b1;
    out_last  = 1'b0;
    case (st)
      FD_LEAD: begin
        out_valid = 1'b1;
        out_bit   = LEAD_PAT[LTOP - lidx];
      end
      FD_BYTE: begin
        out_valid = have;
        out_bit   = sreg[BYTE_W-1];
        out_last  = blast && (bidx == BTOP);
      end
      FD_BITS: begin
        out_valid = zb_valid;
        out_bit   = zb_bit;
        out_last  = zb_last;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= FD_OFF;
      sreg  <= '0;
      lidx  <= '0;
      bidx  <= '0;
      have  <= 1'b0;
      blast <= 1'b0;
    end else if (go) begin
      st   <= packed_mode ? FD_LEAD : FD_BYTE;
      lidx <= '0;
      bidx <= '0;
      have <= 1'b0;
    end else if (clear) begin
      st   <= FD_OFF;
      have <= 1'b0;
    end else begin
      case (st)
        FD_LEAD: if (out_ready) begin
          lidx <= lidx + 1'b1;
          if (lidx == LTOP) st <= FD_BITS;
        end
        FD_BYTE: begin
          if (byte_valid && byte_ready) begin
            sreg  <= byte_data;
            have  <= 1'b1;
            blast <= byte_last;
            bidx  <= '0;
          end else if (have && out_ready) begin
            sreg <= sreg << 1;
            bidx <= bidx + 1'b1;
            if (bidx == BTOP) begin
              have <= 1'b0;
              if (blast) st <= FD_OFF;
            end
          end
        end
        FD_BITS: if (zb_valid && out_ready && zb_last) st <= FD_OFF;
        default: ;
      endcase
    end
  end

  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_ready, zb_ready})); // R5
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfgl_pkg::*;
#(
  parameter int STEP_CYC   = 4,
  parameter int POLL_CYC   = 100000,
  parameter int POLL_LIMIT = 5,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              packed_mode,
  input  logic              init_in,
  input  logic              done_in,
  output logic              prog_n,
  output logic              cclk,
  output logic              cdata,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_last,
  output logic              byte_ready,
  input  logic              zb_valid,
  input  logic              zb_bit,
  input  logic              zb_last,
  output logic              zb_ready,
  output logic              busy,
  output logic              ok,
  output logic [1:0]        err_code
);
  seq_state_t state;
  logic [1:0] init_sy, done_sy;
  logic       mode_q, can_start, cond, arm, met, expired, go, fin;
  logic       s_valid, s_bit, s_last, s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_sy <= 2'b11;
      done_sy <= 2'b00;
    end else begin
      init_sy <= {init_sy[0], init_in};
      done_sy <= {done_sy[0], done_in};
    end
  end

  assign can_start = start &&
    (state == ST_IDLE || state == ST_OK || state == ST_ERR);

  always_comb begin
    case (state)
      ST_FALL: cond = !init_sy[1];
      ST_RISE: cond = init_sy[1];
      default: cond = done_sy[1];
    endcase
  end

  assign arm  = can_start || (state == ST_FALL && met) ||
                (state == ST_RISE && met) || (state == ST_SHIFT && fin);
  assign go   = (state == ST_RISE) && met;
  assign busy = (state == ST_FALL) || (state == ST_RISE) ||
                (state == ST_SHIFT) || (state == ST_DONE);

  cfgl_poller #(.POLL_CYC(POLL_CYC), .POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cond(cond),
    .met(met), .expired(expired)
  );

  cfgl_feed #(.BYTE_W(BYTE_W)) u_feed (
    .clk(clk), .rst_n(rst_n), .go(go), .clear(state != ST_SHIFT),
    .packed_mode(mode_q),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_last(byte_last),
    .byte_ready(byte_ready),
    .zb_valid(zb_valid), .zb_bit(zb_bit), .zb_last(zb_last), .zb_ready(zb_ready),
    .out_valid(s_valid), .out_bit(s_bit), .out_last(s_last), .out_ready(s_ready)
  );

  cfgl_bitser #(.STEP_CYC(STEP_CYC)) u_ser (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_bit(s_bit),
    .in_last(s_last), .in_ready(s_ready), .cclk(cclk), .cdata(cdata), .fin(fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      prog_n   <= 1'b1;
      ok       <= 1'b0;
      err_code <= ERR_NONE;
      mode_q   <= 1'b0;
    end else if (can_start) begin
      state    <= ST_FALL;
      prog_n   <= 1'b0;
      ok       <= 1'b0;
      err_code <= ERR_NONE;
      mode_q   <= packed_mode;
    end else begin
      case (state)
        ST_FALL: if (met) begin
          state  <= ST_RISE;
          prog_n <= 1'b1;
        end else if (expired) begin
          state    <= ST_ERR;
          prog_n   <= 1'b1;
          err_code <= ERR_INIT_FALL;
        end
        ST_RISE: if (met) begin
          state <= ST_SHIFT;
        end else if (expired) begin
          state    <= ST_ERR;
          err_code <= ERR_INIT_RISE;
        end
        ST_SHIFT: if (fin) state <= ST_DONE;
        ST_DONE: if (met) begin
          state <= ST_OK;
          ok    <= 1'b1;
        end else if (expired) begin
          state    <= ST_ERR;
          err_code <= ERR_DONE;
        end
        default: ;
      endcase
    end
  end

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != ERR_NONE && !start) |=> $stable(err_code)); // R9
  AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (err_code == ERR_NONE && !busy)); // R8
  AST_QUIET_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FALL || state == ST_RISE) |-> (cclk && !byte_ready && !zb_ready)); // R10
  AST_PROG_HIGH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT) |-> prog_n); // R2
endmodule

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;
  localparam int STEP = 2, POLL = 20, LIM = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, packed_mode = 1'b0;
  logic init_in, done_in, prog_n, cclk, cdata, busy, ok;
  logic [1:0] err_code;
  logic byte_valid = 1'b0, byte_last = 1'b0, byte_ready;
  logic [7:0] byte_data = 8'h00;
  logic zb_valid = 1'b0, zb_bit = 1'b0, zb_last = 1'b0, zb_ready;

  int nchk = 0, nfail = 0;
  int init_mode = 2;
  logic done_en = 1'b0;
  int exp_bits = 0, nbits = 0, bad_fall = 0, prog_low_shift = 0, rdy_seen = 0;
  logic [63:0] cap = '0;

  always #2.5 clk = ~clk;

  assign init_in = (init_mode == 0) ? 1'b1 : (init_mode == 1) ? 1'b0 : prog_n;
  assign done_in = done_en && (nbits >= exp_bits);

  cfg_serial_loader #(.STEP_CYC(STEP), .POLL_CYC(POLL), .POLL_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .packed_mode(packed_mode),
    .init_in(init_in), .done_in(done_in), .prog_n(prog_n), .cclk(cclk),
    .cdata(cdata), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_last(byte_last), .byte_ready(byte_ready), .zb_valid(zb_valid),
    .zb_bit(zb_bit), .zb_last(zb_last), .zb_ready(zb_ready), .busy(busy),
    .ok(ok), .err_code(err_code)
  );

  always @(posedge cclk) begin
    cap = {cap[62:0], cdata};
    nbits = nbits + 1;
  end
  always @(negedge cclk) begin
    if (!cdata) bad_fall = bad_fall + 1;
    if (!prog_n) prog_low_shift = prog_low_shift + 1;
  end
  always @(negedge clk) if (byte_ready || zb_ready) rdy_seen = rdy_seen + 1;

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    cap = '0; nbits = 0; bad_fall = 0; prog_low_shift = 0; rdy_seen = 0;
  endtask

  task automatic pulse_start(input logic pm);
    packed_mode = pm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic send_bytes(input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input int n);
    for (int i = 0; i < n; i++) begin
      byte_valid = 1'b1;
      byte_data  = (i == 0) ? b0 : (i == 1) ? b1 : b2;
      byte_last  = (i == n - 1);
      while (!byte_ready) @(negedge clk);
      @(negedge clk);
      byte_valid = 1'b0;
    end
  endtask

  task automatic send_bits(input logic [4:0] v);
    for (int i = 4; i >= 0; i--) begin
      zb_valid = 1'b1;
      zb_bit   = v[i];
      zb_last  = (i == 0);
      while (!zb_ready) @(negedge clk);
      @(negedge clk);
      zb_valid = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1 prog_n", prog_n, 1);
    chk("R1 cclk", cclk, 1);
    chk("R1 cdata", cdata, 1);
    chk("R1 busy", busy, 0);
    chk("R1 ok", ok, 0);
    chk("R1 err_code", err_code, 0);
  endtask

  task automatic t_init_no_fall();
    int cnt;
    init_mode = 0; clear_mon();
    pulse_start(1'b0);
    chk("R2 prog_n low after start", prog_n, 0);
    cnt = 0;
    while (err_code == 2'd0 && cnt < 1000) begin
      @(negedge clk);
      cnt++;
    end
    chk("R3 timeout cycles", cnt, (LIM - 1) * POLL + 1);
    chk("R8 code init fall", err_code, 1);
    chk("R10 no clock pulses", nbits, 0);
    chk("R10 no ready", rdy_seen, 0);
    repeat (50) @(negedge clk);
    chk("R9 code held", err_code, 1);
    chk("R9 pins high", {prog_n, cclk, cdata}, 3'b111);
    chk("R9 not busy", busy, 0);
  endtask

  task automatic t_init_no_rise();
    init_mode = 1; clear_mon();
    pulse_start(1'b0);
    chk("R9 restart busy", busy, 1);
    chk("R9 restart clears code", err_code, 0);
    wait_idle();
    chk("R8 code init rise", err_code, 2);
    chk("R10 no clock pulses", nbits, 0);
    chk("R10 no ready", rdy_seen, 0);
  endtask

  task automatic t_done_missing();
    init_mode = 2; done_en = 1'b0; exp_bits = 16; clear_mon();
    fork
      pulse_start(1'b0);
      send_bytes(8'hA5, 8'h3C, 8'h00, 2);
    join
    wait_idle();
    chk("R5 bit count", nbits, 16);
    chk("R5 msb first", cap[15:0], 16'hA53C);
    chk("R8 code done", err_code, 3);
    chk("R8 ok low", ok, 0);
  endtask

  task automatic t_bytes_ok();
    init_mode = 2; done_en = 1'b1; exp_bits = 24; clear_mon();
    fork
      pulse_start(1'b0);
      send_bytes(8'h80, 8'h01, 8'hFF, 3);
    join
    wait_idle();
    chk("R7 bit count", nbits, 24);
    chk("R5 byte order", cap[23:0], 24'h8001FF);
    chk("R8 ok", ok, 1);
    chk("R8 code none", err_code, 0);
    chk("R4 data high at fall", bad_fall, 0);
    chk("R2 prog high while shifting", prog_low_shift, 0);
  endtask

  task automatic t_packed_ok();
    init_mode = 2; done_en = 1'b1; exp_bits = 21; clear_mon();
    fork
      pulse_start(1'b1);
      send_bits(5'b10011);
    join
    wait_idle();
    chk("R6 bit count", nbits, 21);
    chk("R6 lead then stream", cap[20:0], {16'hFF20, 5'b10011});
    chk("R8 ok", ok, 1);
    chk("R4 data high at fall", bad_fall, 0);
    repeat (30) @(negedge clk);
    chk("R9 ok held", ok, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_no_fall();
    t_init_no_rise();
    t_done_missing();
    t_bytes_ok();
    t_packed_ok();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule